// File: doc/BRIEF.md
# Clock Source Selection and Division Unit

This block sits in the clock-management corner of a small microcontroller and turns a few raw timing ticks into the enables the rest of the chip runs on. It takes three single-cycle ticks in one master clock domain: a tick from a 500 kHz RC base, a tick from a 32.768 kHz crystal reference, and a tick from an external clock input. From them it derives five single-cycle enables: a low-speed enable, a low-speed enable at twice that rate, a high-speed enable, a system enable and an output-pin enable. The crystal tick is taken to arrive on both crystal edges, so it already runs at twice the low-speed rate.

Two small control registers, written and read over a plain register bus, choose the sources and the divide ratios. The block leaves reset with the system enable running at the RC base divided by 8. Any change of a source or of a ratio is held back until the enable it affects produces a pulse under the old setting, so a switch never emits a short period. A build parameter can tie the system enable to the high-speed path and remove the external clock choice.

Top module: `clk_select_div`

## Requirements
- R1: After reset, control register 0 (address 0) reads 0x6 and control register 1 (address 1) reads 0x2 (0x0 in the fixed build); the system enable pulses once every 8 RC ticks and the output enable once every RC tick.
- R2: Register 0 bit 0 selects the high-speed source: 0 gives one high-speed enable per RC tick, 1 gives one per external tick.
- R3: With register 1 bit 0 at 0 (crystal), the doubled low-speed enable pulses on every crystal tick and the low-speed enable on every second one.
- R4: With register 1 bit 0 at 1 (RC), the doubled low-speed enable pulses once per 8 RC ticks and the low-speed enable once per 16 RC ticks.
- R5: Register 1 bit 1 selects the source counted by the system divider: 0 the low-speed enable, 1 the high-speed enable.
- R6: Register 0 bits 2:1 hold a value n, and the system enable pulses once per 2^n pulses of its source (n = 0 to 3).
- R7: Register 1 bits 3:2 hold a value m, and the output enable pulses once per 2^m high-speed enables.
- R8: A new source or ratio takes effect at the next pulse of the affected enable under the old setting, and that divider then counts from zero, so every period seen across a ratio change equals either the old or the new period.
- R9: Read data returns the written values of the defined bits; bit 3 of register 0 always reads 0.
- R10: In the fixed build, the system enable always counts high-speed enables, the high-speed enable always follows the RC tick, and register 0 bit 0 and register 1 bit 1 read 0 whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rc_tick_i | input | 1 | Single-cycle tick of the 500 kHz RC base |
| xtal_tick_i | input | 1 | Single-cycle tick on each crystal edge |
| ext_tick_i | input | 1 | Single-cycle tick of the external clock |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | Register select (0 or 1) |
| bus_wdata_i | input | 4 | Write data |
| bus_rdata_o | output | 4 | Read data for the selected register |
| ls_en_o | output | 1 | Low-speed enable |
| ls2_en_o | output | 1 | Doubled low-speed enable |
| hs_en_o | output | 1 | High-speed enable |
| sys_en_o | output | 1 | System enable |
| out_en_o | output | 1 | Output-pin enable |

## Verification
The three input ticks run at co-prime spacings of 4, 5 and 3 master cycles, so every source choice yields a distinct pulse spacing on each enable and a wrong source or ratio cannot hide behind a matching period. Random register settings cover the source and ratio space, while directed steps cover the reset setting, the slowest path (RC low-speed into a 1/8 system divide) and ratio changes in both directions, where every period across the change must be the old or the new one. A second instance in the fixed build shares all stimulus and shows that the tied-off choices change neither its enables nor its read data.

// File: rtl/csd_pkg.sv
package csd_pkg;

   localparam int DIV_W  = 2;
   localparam int DATA_W = 4;

   localparam logic [DATA_W-1:0] R0_RST = 4'h6;
   localparam logic [DATA_W-1:0] R1_RST = 4'h2;

   function automatic logic [DATA_W-1:0] r0_mask(input bit fixed_hs);
      return fixed_hs ? 4'h6 : 4'h7;
   endfunction

   function automatic logic [DATA_W-1:0] r1_mask(input bit fixed_hs);
      return fixed_hs ? 4'hD : 4'hF;
   endfunction

endpackage

// File: rtl/csd_div.sv
module csd_div #(
   parameter int               DIV_W     = 2,
   parameter logic [DIV_W-1:0] RST_RATIO = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [DIV_W-1:0] ratio_i,
   output logic             pulse_o
);

   localparam int CNT_W = (1 << DIV_W) - 1;

   if (DIV_W < 1 || DIV_W > 4) begin : g_chk
      $error("csd_div: DIV_W out of range");
   end

   logic [DIV_W-1:0] ratio_act;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;

   always_comb begin
      lim     = CNT_W'((1 << ratio_act) - 1);
      pulse_o = tick_i && (cnt == lim);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         ratio_act <= RST_RATIO;
      end else if (pulse_o) begin
         cnt       <= '0;
         ratio_act <= ratio_i;
      end else if (tick_i) begin
         cnt <= cnt + 1'b1;
      end
   end

   p_cnt_bound_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= lim);
   p_ratio_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !pulse_o |=> $stable(ratio_act));
   p_restart_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> (cnt == '0));

endmodule

// File: rtl/csd_regs.sv
module csd_regs import csd_pkg::*; #(
   parameter bit FIXED_HS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic              addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              hs_ext_o,
   output logic [DIV_W-1:0]  sys_div_o,
   output logic              ls_rc_o,
   output logic              sys_hs_o,
   output logic [DIV_W-1:0]  out_div_o
);

   localparam logic [DATA_W-1:0] M0 = r0_mask(FIXED_HS);
   localparam logic [DATA_W-1:0] M1 = r1_mask(FIXED_HS);

   logic [DATA_W-1:0] r0_q, r1_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r0_q <= R0_RST & M0;
         r1_q <= R1_RST & M1;
      end else if (we_i) begin
         if (addr_i) r1_q <= wdata_i & M1;
         else        r0_q <= wdata_i & M0;
      end
   end

   always_comb begin
      rdata_o   = addr_i ? r1_q : r0_q;
      hs_ext_o  = r0_q[0];
      sys_div_o = r0_q[2:1];
      ls_rc_o   = r1_q[0];
      sys_hs_o  = r1_q[1];
      out_div_o = r1_q[3:2];
   end

   p_rsvd_zero_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && !addr_i) |=> (r0_q[3] == 1'b0));

endmodule

// File: rtl/csd_ls_gen.sv
module csd_ls_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic xtal_tick_i,
   input  logic rc_ls2_i,
   input  logic ls_rc_i,
   output logic ls2_en_o,
   output logic ls_en_o
);

   logic ls_rc_act;
   logic phase;

   always_comb begin
      ls2_en_o = ls_rc_act ? rc_ls2_i : xtal_tick_i;
      ls_en_o  = ls2_en_o && phase;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ls_rc_act <= 1'b0;
         phase     <= 1'b0;
      end else begin
         if (ls2_en_o) phase     <= ~phase;
         if (ls_en_o)  ls_rc_act <= ls_rc_i;
      end
   end

   p_ls_src_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !ls_en_o |=> $stable(ls_rc_act));
   p_half_rate_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      ls_en_o |=> !phase);

endmodule

// File: rtl/clk_select_div.sv
module clk_select_div import csd_pkg::*; #(
   parameter bit FIXED_HS = 1'b0,
   parameter int LS2_LOG  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rc_tick_i,
   input  logic              xtal_tick_i,
   input  logic              ext_tick_i,
   input  logic              bus_we_i,
   input  logic              bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              ls_en_o,
   output logic              ls2_en_o,
   output logic              hs_en_o,
   output logic              sys_en_o,
   output logic              out_en_o
);

   localparam logic [DIV_W-1:0] PRE_RATIO = DIV_W'(LS2_LOG);

   if (LS2_LOG < 0 || LS2_LOG >= (1 << DIV_W)) begin : g_chk
      $error("clk_select_div: LS2_LOG does not fit the divider");
   end

   logic             cfg_hs_ext, cfg_ls_rc, cfg_sys_hs;
   logic [DIV_W-1:0] cfg_sys_div, cfg_out_div;
   logic             rc_ls2, hs_en, sys_tick;

   csd_regs #(.FIXED_HS(FIXED_HS)) u_regs (
      .clk(clk), .rst_n(rst_n), .we_i(bus_we_i), .addr_i(bus_addr_i),
      .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
      .hs_ext_o(cfg_hs_ext), .sys_div_o(cfg_sys_div), .ls_rc_o(cfg_ls_rc),
      .sys_hs_o(cfg_sys_hs), .out_div_o(cfg_out_div)
   );

   csd_div #(.DIV_W(DIV_W), .RST_RATIO(PRE_RATIO)) u_rc_pre (
      .clk(clk), .rst_n(rst_n), .tick_i(rc_tick_i),
      .ratio_i(PRE_RATIO), .pulse_o(rc_ls2)
   );

   csd_ls_gen u_ls (
      .clk(clk), .rst_n(rst_n), .xtal_tick_i(xtal_tick_i), .rc_ls2_i(rc_ls2),
      .ls_rc_i(cfg_ls_rc), .ls2_en_o(ls2_en_o), .ls_en_o(ls_en_o)
   );

   if (FIXED_HS) begin : g_fixed
      assign hs_en    = rc_tick_i;
      assign sys_tick = hs_en;
   end else begin : g_sel
      logic hs_ext_act, sys_hs_act;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hs_ext_act <= 1'b0;
            sys_hs_act <= 1'b1;
         end else begin
            if (hs_en)    hs_ext_act <= cfg_hs_ext;
            if (sys_en_o) sys_hs_act <= cfg_sys_hs;
         end
      end

      assign hs_en    = hs_ext_act ? ext_tick_i : rc_tick_i;
      assign sys_tick = sys_hs_act ? hs_en : ls_en_o;

      p_hs_src_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
         !hs_en |=> $stable(hs_ext_act));
      p_sys_src_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
         !sys_en_o |=> $stable(sys_hs_act));
   end

   csd_div #(.DIV_W(DIV_W), .RST_RATIO(DIV_W'(3))) u_sys_div (
      .clk(clk), .rst_n(rst_n), .tick_i(sys_tick),
      .ratio_i(cfg_sys_div), .pulse_o(sys_en_o)
   );

   csd_div #(.DIV_W(DIV_W), .RST_RATIO('0)) u_out_div (
      .clk(clk), .rst_n(rst_n), .tick_i(hs_en),
      .ratio_i(cfg_out_div), .pulse_o(out_en_o)
   );

   assign hs_en_o = hs_en;

   p_sys_needs_src_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      sys_en_o |-> (hs_en_o || ls_en_o));
   p_out_needs_hs_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      out_en_o |-> hs_en_o);

endmodule

// File: tb/clk_select_div_tb.sv
`timescale 1ns/1ps
module clk_select_div_tb;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       rc_tick = 0, xtal_tick = 0, ext_tick = 0;
   logic       we = 0, addr = 0;
   logic [3:0] wdata = '0;
   logic [3:0] rdata, rdata_f;
   logic       ls, ls2, hs, sys, outc;
   logic       f_ls, f_ls2, f_hs, f_sys, f_out;

   int checks = 0, fails = 0;
   bit done = 0;
   int cyc = 0;
   int exp_q[7];
   string tag_q[7];

   clk_select_div #(.FIXED_HS(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .rc_tick_i(rc_tick), .xtal_tick_i(xtal_tick),
      .ext_tick_i(ext_tick), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
      .bus_rdata_o(rdata), .ls_en_o(ls), .ls2_en_o(ls2), .hs_en_o(hs),
      .sys_en_o(sys), .out_en_o(outc)
   );

   clk_select_div #(.FIXED_HS(1'b1)) u_dut_fix (
      .clk(clk), .rst_n(rst_n), .rc_tick_i(rc_tick), .xtal_tick_i(xtal_tick),
      .ext_tick_i(ext_tick), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
      .bus_rdata_o(rdata_f), .ls_en_o(f_ls), .ls2_en_o(f_ls2), .hs_en_o(f_hs),
      .sys_en_o(f_sys), .out_en_o(f_out)
   );

   // tick sources: RC every 4, crystal edge every 5, external every 3 cycles
   always @(negedge clk) begin
      cyc       <= cyc + 1;
      rc_tick   <= (cyc % 4) == 0;
      xtal_tick <= (cyc % 5) == 2;
      ext_tick  <= (cyc % 3) == 1;
   end

   function automatic int hs_per(input bit hsx);
      return hsx ? 3 : 4;
   endfunction
   function automatic int ls2_per(input bit lsr);
      return lsr ? 32 : 5;
   endfunction

   task automatic set_exp(input bit hsx, input bit [1:0] sd, input bit lsr,
                          input bit ssrc, input bit [1:0] od);
      exp_q[0] = hs_per(hsx);
      exp_q[1] = ls2_per(lsr);
      exp_q[2] = 2 * ls2_per(lsr);
      exp_q[3] = (ssrc ? hs_per(hsx) : 2 * ls2_per(lsr)) << sd;
      exp_q[4] = hs_per(hsx) << od;
      exp_q[5] = 4;
      exp_q[6] = 4 << sd;
      tag_q[0] = "R2 hs";
      tag_q[1] = lsr ? "R4 ls2" : "R3 ls2";
      tag_q[2] = lsr ? "R4 ls"  : "R3 ls";
      tag_q[3] = "R5/R6 sys";
      tag_q[4] = "R7 out";
      tag_q[5] = "R10 fixed hs";
      tag_q[6] = "R10 fixed sys";
   endtask

   task automatic check_eq(input string tag, input int act, input int expv);
      checks++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic bus_write(input bit a, input logic [3:0] d);
      @(negedge clk);
      we = 1; addr = a; wdata = d;
      @(negedge clk);
      we = 0;
   endtask

   task automatic read_check(input bit a, input logic [3:0] e, input logic [3:0] ef,
                             input string tag);
      @(negedge clk);
      addr = a;
      #1;
      check_eq({tag, " readback"}, int'(rdata), int'(e));
      check_eq({tag, " fixed readback"}, int'(rdata_f), int'(ef));
   endtask

   task automatic measure(input int n);
      int last[7], bad[7], badv[7], cnt[7];
      logic [6:0] obs;
      for (int k = 0; k < 7; k++) begin
         last[k] = -1; bad[k] = 0; badv[k] = 0; cnt[k] = 0;
      end
      for (int c = 0; c < n; c++) begin
         @(negedge clk); #1;
         obs = {f_sys, f_hs, outc, sys, ls, ls2, hs};
         for (int k = 0; k < 7; k++) begin
            if (obs[k]) begin
               if (last[k] >= 0) begin
                  cnt[k]++;
                  if (c - last[k] != exp_q[k]) begin
                     if (bad[k] == 0) badv[k] = c - last[k];
                     bad[k]++;
                  end
               end
               last[k] = c;
            end
         end
      end
      for (int k = 0; k < 7; k++) begin
         checks++;
         if (bad[k] != 0 || cnt[k] < 2) begin
            fails++;
            $display("FAIL %s: interval actual %0d expected %0d (%0d intervals)",
                     tag_q[k], badv[k], exp_q[k], cnt[k]);
         end
      end
   endtask

   // R8: across a ratio change every system period is the old or the new one
   task automatic trans_check(input int n, input int old_p, input int new_p);
      int last = -1, bad = 0, badv = 0, seen_new = 0;
      for (int c = 0; c < n; c++) begin
         @(negedge clk); #1;
         if (sys) begin
            if (last >= 0) begin
               if (c - last == new_p) seen_new++;
               else if (c - last != old_p) begin
                  if (bad == 0) badv = c - last;
                  bad++;
               end
            end
            last = c;
         end
      end
      checks++;
      if (bad != 0 || seen_new == 0) begin
         fails++;
         $display("FAIL R8 transition: interval actual %0d expected %0d or %0d",
                  badv, old_p, new_p);
      end
   endtask

   task automatic apply(input bit hsx, input bit [1:0] sd, input bit lsr,
                        input bit ssrc, input bit [1:0] od);
      bus_write(1'b0, {$urandom_range(1), sd, hsx});
      bus_write(1'b1, {od, ssrc, lsr});
      read_check(1'b0, {1'b0, sd, hsx}, {1'b0, sd, 1'b0}, "R9 reg0");
      read_check(1'b1, {od, ssrc, lsr}, {od, 1'b0, lsr}, "R9 reg1");
      set_exp(hsx, sd, lsr, ssrc, od);
      repeat (1300) @(negedge clk);
      measure(1600);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values and reset rates
      read_check(1'b0, 4'h6, 4'h6, "R1 reg0");
      read_check(1'b1, 4'h2, 4'h0, "R1 reg1");
      set_exp(1'b0, 2'd3, 1'b0, 1'b1, 2'd0);
      tag_q[3] = "R1 sys";
      tag_q[4] = "R1 out";
      measure(1600);

      // R9: all ones written, reserved bit reads 0
      bus_write(1'b0, 4'hF);
      bus_write(1'b1, 4'hF);
      read_check(1'b0, 4'h7, 4'h6, "R9 reg0 ones");
      read_check(1'b1, 4'hF, 4'hD, "R9 reg1 ones");

      // slowest path and fastest external path
      apply(1'b0, 2'd3, 1'b1, 1'b0, 2'd3);
      apply(1'b1, 2'd0, 1'b0, 1'b1, 2'd0);

      // R8: ratio changes on the RC high-speed path
      apply(1'b0, 2'd0, 1'b0, 1'b1, 2'd1);
      bus_write(1'b0, 4'b0110);
      trans_check(800, 4, 32);
      bus_write(1'b0, 4'b0010);
      trans_check(800, 32, 8);

      for (int i = 0; i < 12; i++) begin
         apply(1'($urandom_range(1)), 2'($urandom_range(3)), 1'($urandom_range(1)),
               1'($urandom_range(1)), 2'($urandom_range(3)));
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule